// File: doc/BRIEF.md
# Two-Stage Overtemperature Guard

This block watches the die temperature through four digital comparator levels. The levels are an upper and a lower threshold for each of two stages. It keeps a latched overtemperature status for each stage. Each status has hysteresis: it is set by its upper comparator and cleared only by its lower one. Each stage also raises a sticky interrupt flag when its status is newly set. The flags drive a shared interrupt request until the host clears them with an end-of-interrupt pulse.

The first stage only warns. The second stage also makes the I/O stages safe. It drops the pull-resistor enable, and it holds a clear command to the output and flash-enable configuration registers for as long as the status stays set. That clear also overrides host writes while the hot condition lasts. When the second stage releases, the pull resistors come back on. The output and flash-enable configuration stays cleared, and the host must write it again.

The comparator levels are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops. A comparator change therefore reaches the status outputs `SYNC_STAGES + 1` clock edges later. The end-of-interrupt input is synchronous to `clk`. All pins are plain level signals. There is no streaming data path, so no valid/ready handshake applies.

Top module: `thermal_guard`

## Requirements
- R1: After reset both status outputs, both interrupt flags and `irq_o` are 0, `pull_en_o` is 1 and `cfg_clr_o` is 0.
- R2: When `trip1_i` is asserted while `hot1_o` is 0, both `hot1_o` and `flag1_o` become 1 on clock edge `SYNC_STAGES + 1` after the change.
- R3: `hot1_o` stays 1 while neither comparator of stage 1 is asserted. It returns to 0 only when `rel1_i` is asserted.
- R4: Stage 1 never changes `pull_en_o` or `cfg_clr_o`.
- R5: A stage-2 trip sets `hot2_o` and `flag2_o`. While `hot2_o` is 1, `pull_en_o` is 0 and `cfg_clr_o` is 1 on every cycle.
- R6: `hot2_o` clears only when `rel2_i` is asserted. At that point `pull_en_o` returns to 1 and `cfg_clr_o` returns to 0, and any set interrupt flag stays set.
- R7: If a stage's trip and release comparators are both asserted, the trip wins and the status is set.
- R8: Interrupt flags stay set until a cycle with `eoi_i` = 1, which clears both flags on that edge. A trip that sets a flag on the same edge as `eoi_i` takes priority, and that flag stays 1.
- R9: `irq_o` is 1 exactly when at least one interrupt flag is 1.
- R10: A flag is raised only when its status goes from 0 to 1. Keeping the trip comparator asserted after an end-of-interrupt does not raise the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip1_i | input | 1 | Temperature above stage-1 trip level (async) |
| rel1_i | input | 1 | Temperature below stage-1 release level (async) |
| trip2_i | input | 1 | Temperature above stage-2 trip level (async) |
| rel2_i | input | 1 | Temperature below stage-2 release level (async) |
| eoi_i | input | 1 | End-of-interrupt, clears both interrupt flags |
| hot1_o | output | 1 | Stage-1 overtemperature status |
| hot2_o | output | 1 | Stage-2 overtemperature status |
| flag1_o | output | 1 | Stage-1 interrupt flag |
| flag2_o | output | 1 | Stage-2 interrupt flag |
| irq_o | output | 1 | Interrupt request, OR of the flags |
| pull_en_o | output | 1 | Enable for the I/O pull-up/pull-down resistors |
| cfg_clr_o | output | 1 | Clear command for output and flash-enable registers |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. This shows that the latency of the trip, release and flag paths follows the parameter and is not fixed at a constant. With that depth the bench can line up an end-of-interrupt pulse with the exact edge on which a synchronized trip lands, which exercises the set-over-clear rule. It also drives both comparators of a stage at once, which exercises trip priority.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  // Number of hysteresis stages supervised by the guard
  localparam int unsigned NUM_STAGES = 2;
  // Index of the stage that forces the I/O stages safe
  localparam int unsigned SAFE_STAGE = NUM_STAGES - 1;

  // One comparator pair of a stage
  typedef struct packed {
    logic trip;
    logic rel;
  } cmp_pair_t;
endpackage

// File: rtl/thermal_sync.sv
module thermal_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flop
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[DEPTH-1];
endmodule

// File: rtl/thermal_hyst.sv
module thermal_hyst
  import thermal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmp_pair_t cmp_i,
  input  logic      eoi_i,
  output logic      status_o,
  output logic      flag_o
);
  logic status_q;
  logic flag_q;

  // Trip is evaluated before release; a new trip outranks an end-of-interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (cmp_i.trip)     status_q <= 1'b1;
      else if (cmp_i.rel) status_q <= 1'b0;

      if (cmp_i.trip && !status_q) flag_q <= 1'b1;
      else if (eoi_i)              flag_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign flag_o   = flag_q;

  // R7
  trip_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_i.trip |=> status_q);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_i.trip && !cmp_i.rel) |=> $stable(status_q));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !eoi_i) |=> flag_q);

  // R10
  no_reraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $rose(status_q));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip1_i,
  input  logic rel1_i,
  input  logic trip2_i,
  input  logic rel2_i,
  input  logic eoi_i,
  output logic hot1_o,
  output logic hot2_o,
  output logic flag1_o,
  output logic flag2_o,
  output logic irq_o,
  output logic pull_en_o,
  output logic cfg_clr_o
);
  localparam int unsigned CMP_W = 2 * NUM_STAGES;

  logic [CMP_W-1:0]      raw_cmp;
  logic [CMP_W-1:0]      sync_cmp;
  logic [NUM_STAGES-1:0] status;
  logic [NUM_STAGES-1:0] flag;

  assign raw_cmp = {trip2_i, rel2_i, trip1_i, rel1_i};

  thermal_sync #(
    .WIDTH (CMP_W),
    .DEPTH (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_cmp),
    .sync_o  (sync_cmp)
  );

  generate
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      cmp_pair_t pair;
      assign pair.trip = sync_cmp[2*s+1];
      assign pair.rel  = sync_cmp[2*s];

      thermal_hyst i_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_i    (pair),
        .eoi_i    (eoi_i),
        .status_o (status[s]),
        .flag_o   (flag[s])
      );
    end
  endgenerate

  assign hot1_o    = status[0];
  assign hot2_o    = status[1];
  assign flag1_o   = flag[0];
  assign flag2_o   = flag[1];
  assign irq_o     = |flag;
  assign pull_en_o = !status[SAFE_STAGE];
  assign cfg_clr_o = status[SAFE_STAGE];

  // R6
  release_restores_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[SAFE_STAGE] && !sync_cmp[2*SAFE_STAGE+1] && sync_cmp[2*SAFE_STAGE])
      |=> (pull_en_o && !cfg_clr_o));

  // R5
  trip_forces_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cmp[2*SAFE_STAGE+1] |=> (!pull_en_o && cfg_clr_o && hot2_o));
endmodule

// File: tb/test_thermal_guard.sv
module test_thermal_guard;
  localparam int unsigned SYNC = 3;
  localparam int unsigned LAT  = SYNC + 1;

  typedef struct {
    logic  h1, h2, f1, f2, irq, pull, clr;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip1 = 1'b0, rel1 = 1'b0, trip2 = 1'b0, rel2 = 1'b0, eoi = 1'b0;
  logic hot1, hot2, flag1, flag2, irq, pull_en, cfg_clr;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 1'b0;
  exp_t exp_q[$];

  // model state
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_f1 = 1'b0, m_f2 = 1'b0;

  always #10 clk = ~clk;

  thermal_guard #(.SYNC_STAGES(SYNC)) i_thermal_guard (
    .clk(clk), .rst_n(rst_n),
    .trip1_i(trip1), .rel1_i(rel1), .trip2_i(trip2), .rel2_i(rel2),
    .eoi_i(eoi),
    .hot1_o(hot1), .hot2_o(hot2), .flag1_o(flag1), .flag2_o(flag2),
    .irq_o(irq), .pull_en_o(pull_en), .cfg_clr_o(cfg_clr)
  );

  task automatic push_exp(input string tag);
    exp_t e;
    e.h1 = m_s1; e.h2 = m_s2; e.f1 = m_f1; e.f2 = m_f2;
    e.irq = m_f1 | m_f2; e.pull = !m_s2; e.clr = m_s2; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic model_stage(input logic t, input logic r,
                             inout logic s, inout logic f);
    if (t) begin
      if (!s) f = 1'b1;
      s = 1'b1;
    end else if (r) begin
      s = 1'b0;
    end
  endtask

  // Driver: hold comparator levels until they have propagated
  task automatic apply(input logic t1, input logic r1, input logic t2,
                       input logic r2, input string tag);
    @(negedge clk);
    trip1 = t1; rel1 = r1; trip2 = t2; rel2 = r2;
    repeat (LAT) @(posedge clk);
    model_stage(t1, r1, m_s1, m_f1);
    model_stage(t2, r2, m_s2, m_f2);
    push_exp(tag);
  endtask

  task automatic pulse_eoi(input string tag);
    @(negedge clk);
    eoi = 1'b1;
    @(posedge clk);
    m_f1 = 1'b0; m_f2 = 1'b0;
    push_exp(tag);
    @(negedge clk);
    eoi = 1'b0;
  endtask

  // Stage-1 trip lands on the same edge as an end-of-interrupt
  task automatic trip_with_eoi(input string tag);
    @(negedge clk);
    trip1 = 1'b1; rel1 = 1'b0; trip2 = 1'b0; rel2 = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    eoi = 1'b1;
    @(posedge clk);
    m_f1 = 1'b0; m_f2 = 1'b0;
    model_stage(1'b1, 1'b0, m_s1, m_f1);
    model_stage(1'b0, 1'b0, m_s2, m_f2);
    push_exp(tag);
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic chk(input string tag, input string name,
                     input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "hot1",    hot1,    e.h1);
        chk(e.tag, "hot2",    hot2,    e.h2);
        chk(e.tag, "flag1",   flag1,   e.f1);
        chk(e.tag, "flag2",   flag2,   e.f2);
        chk(e.tag, "irq",     irq,     e.irq);
        chk(e.tag, "pull_en", pull_en, e.pull);
        chk(e.tag, "cfg_clr", cfg_clr, e.clr);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    push_exp("R1 reset state");
    apply(1'b0, 1'b1, 1'b0, 1'b1, "R1 idle cool");
    apply(1'b1, 1'b0, 1'b0, 1'b0, "R2 R4 R9 stage1 trip");
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R3 stage1 hold");
    pulse_eoi("R8 eoi clears flag1");
    apply(1'b1, 1'b0, 1'b0, 1'b0, "R10 held trip no reraise");
    apply(1'b0, 1'b1, 1'b0, 1'b0, "R3 stage1 release");
    apply(1'b1, 1'b0, 1'b1, 1'b0, "R5 stage2 trip");
    apply(1'b0, 1'b1, 1'b0, 1'b0, "R5 R6 stage2 holds safe");
    apply(1'b0, 1'b1, 1'b0, 1'b1, "R6 stage2 release flags persist");
    pulse_eoi("R8 R9 eoi clears both");
    apply(1'b1, 1'b1, 1'b1, 1'b1, "R7 trip beats release");
    apply(1'b0, 1'b1, 1'b0, 1'b1, "R7 release after both");
    pulse_eoi("R8 clear before race");
    trip_with_eoi("R8 set wins over eoi");
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R8 flag kept after race");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule